// File: doc/BRIEF.md
# Programmable Pin Deglitch Filter

This block cleans up one slow-moving input pin before its level is used elsewhere on the chip. The filtered level feeds both the pin's status bit and the interrupt logic. The raw pin is first brought into the core clock domain by a two-flop synchronizer. It is then judged against a time window built from a slow real-time tick. The tick is a one-cycle enable pulse that is synchronous to the core clock.

A 4-bit count field and two unit-select bits set the window length. The length is the count times a tick multiple of 2, 8, 512 or 2048. A 2-bit policy field picks one of four behaviours:
- pass the pin straight through;
- reject short pulses of both polarities;
- let pulses toward the low level through at once while the way back is timed (suits interrupts that fire on a high level);
- the mirror of the previous policy, for interrupts that fire on a low level.

Top module: `deglitch_filter`

## Requirements
- R1: While rst_n is low, pin_filt is 0 and the synchronizer stages hold 0.
- R2: With filt_mode = 2'b00 (bypass), pin_filt equals the value pin_raw had three clock edges earlier: two synchronizer stages plus one output register.
- R3: With filt_mode = 2'b11 (reject both), a new synchronized level is adopted only after slow_tick has pulsed span times while that level differs from pin_filt. span = count × unit. With a tick on every cycle, pin_filt changes span+2 edges after pin_raw changes.
- R4: When the synchronized level returns to pin_filt before span ticks have passed, the tick tally is cleared, so a pulse or a bounce train shorter than span ticks never reaches pin_filt.
- R5: The unit is selected by {unit_large, unit_fine}: 2'b00 = 2 ticks, 2'b01 = 8, 2'b10 = 512, 2'b11 = 2048.
- R6: A dbc_count of 0 in a filtering policy behaves as a count of 1, which gives a window of one unit.
- R7: With filt_mode = 2'b01 (keep low pulses), a change of the synchronized level to 0 appears on pin_filt on the next edge without waiting, while a change to 1 is timed as in R3.
- R8: With filt_mode = 2'b10 (keep high pulses), a change to 1 passes on the next edge, while a change to 0 is timed as in R3.
- R9: In a filtering policy, only cycles with slow_tick high advance the window. With no tick, pin_filt holds its value however long the input differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronized pin level |
| slow_tick | input | 1 | One-cycle enable from the slow real-time clock |
| dbc_count | input | CNT_W (4) | Window length in units |
| unit_large | input | 1 | Unit select, upper bit |
| unit_fine | input | 1 | Unit select, lower bit |
| filt_mode | input | 2 | Policy: 00 bypass, 01 keep low pulses, 10 keep high pulses, 11 reject both |
| pin_filt | output | 1 | Filtered pin level |

## Verification
Single clean steps are timed edge by edge under every unit setting, with a zero count and with the longest window. Comparing the measured latency with span+2 tells the four units apart and catches an off-by-one in the window. Pulses a little shorter than the window, and bounce trains of such pulses, separate a tally that restarts from one that accumulates. Sparse ticks and a stopped tick show that only ticks advance the window. One-cycle pulses in both keep policies show which direction passes at once and which one is timed.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef enum logic [1:0] {
        FM_BYPASS    = 2'b00,
        FM_KEEP_LOW  = 2'b01,
        FM_KEEP_HIGH = 2'b10,
        FM_REJECT    = 2'b11
    } filt_mode_e;
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dbf_span.sv
module dbf_span #(
    parameter int CNT_W = 4,
    parameter int ACC_W = 15,
    parameter int SH_0  = 1,
    parameter int SH_1  = 3,
    parameter int SH_2  = 9,
    parameter int SH_3  = 11
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       unit_sel,
    output logic [ACC_W-1:0] span
);
    logic [CNT_W-1:0] eff;
    logic [ACC_W-1:0] base;
    int               sh;

    always_comb begin
        // zero count is treated as one unit
        eff  = (count == '0) ? CNT_W'(1) : count;
        base = {{(ACC_W-CNT_W){1'b0}}, eff};
        case (unit_sel)
            2'b00:   sh = SH_0;
            2'b01:   sh = SH_1;
            2'b10:   sh = SH_2;
            default: sh = SH_3;
        endcase
        span = base << sh;
    end
endmodule

// File: rtl/dbf_core.sv
module dbf_core
    import dbf_pkg::*;
#(
    parameter int ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_lvl,
    input  logic             tick,
    input  filt_mode_e       mode,
    input  logic [ACC_W-1:0] span,
    output logic             level,
    output logic [ACC_W-1:0] acc
);
    typedef struct packed {
        logic             level;
        logic [ACC_W-1:0] acc;
    } core_st_t;

    core_st_t     st_d, st_q;
    logic [ACC_W:0] acc_nx;
    logic           fast_pass;

    always_comb begin
        st_d      = st_q;
        acc_nx    = {1'b0, st_q.acc} + {{ACC_W{1'b0}}, 1'b1};
        fast_pass = (mode == FM_KEEP_LOW  && !sync_lvl) ||
                    (mode == FM_KEEP_HIGH &&  sync_lvl);
        if (mode == FM_BYPASS) begin
            st_d.level = sync_lvl;
            st_d.acc   = '0;
        end else if (sync_lvl == st_q.level) begin
            st_d.acc = '0;
        end else if (fast_pass) begin
            st_d.level = sync_lvl;
            st_d.acc   = '0;
        end else if (tick) begin
            if (acc_nx >= {1'b0, span}) begin
                st_d.level = sync_lvl;
                st_d.acc   = '0;
            end else begin
                st_d.acc = acc_nx[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign acc   = st_q.acc;
endmodule

// File: rtl/deglitch_filter.sv
module deglitch_filter
    import dbf_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SH_0        = 1,
    parameter int SH_1        = 3,
    parameter int SH_2        = 9,
    parameter int SH_3        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             slow_tick,
    input  logic [CNT_W-1:0] dbc_count,
    input  logic             unit_large,
    input  logic             unit_fine,
    input  logic [1:0]       filt_mode,
    output logic             pin_filt
);
    localparam int ACC_W = CNT_W + SH_3;

    logic             sync_lvl;
    logic [ACC_W-1:0] span;
    logic [ACC_W-1:0] acc_cnt;

    dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (sync_lvl)
    );

    dbf_span #(
        .CNT_W (CNT_W), .ACC_W (ACC_W),
        .SH_0  (SH_0),  .SH_1  (SH_1), .SH_2 (SH_2), .SH_3 (SH_3)
    ) u_span (
        .count    (dbc_count),
        .unit_sel ({unit_large, unit_fine}),
        .span     (span)
    );

    dbf_core #(.ACC_W(ACC_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .tick     (slow_tick),
        .mode     (filt_mode_e'(filt_mode)),
        .span     (span),
        .level    (pin_filt),
        .acc      (acc_cnt)
    );
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
    parameter int ACC_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_raw,
    input logic             slow_tick,
    input logic [1:0]       filt_mode,
    input logic             pin_filt,
    input logic             sync_lvl,
    input logic [ACC_W-1:0] acc_cnt
);
    logic [2:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
    end

    // R2: bypass output is the raw pin three edges late
    p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4 && $past(filt_mode) == 2'b00) |-> pin_filt == $past(pin_raw, 3));

    // R4: tally is clear whenever the input agrees with the output
    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2 && $past(filt_mode) != 2'b00 && $past(sync_lvl) == $past(pin_filt))
        |-> acc_cnt == '0);

    // R7: low pulses pass at once in keep-low
    p_keep_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2 && $past(filt_mode) == 2'b01 && !$past(sync_lvl)) |-> !pin_filt);

    // R8: high pulses pass at once in keep-high
    p_keep_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2 && $past(filt_mode) == 2'b10 && $past(sync_lvl)) |-> pin_filt);

    // R9: no tick, no change while rejecting both
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2 && $past(filt_mode) == 2'b11 && !$past(slow_tick))
        |-> pin_filt == $past(pin_filt));
endmodule

bind deglitch_filter dbf_checker #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .slow_tick (slow_tick),
    .filt_mode (filt_mode),
    .pin_filt  (pin_filt),
    .sync_lvl  (sync_lvl),
    .acc_cnt   (acc_cnt)
);

// File: tb/tb_deglitch_filter.sv
`timescale 1ns/1ps
module tb_deglitch_filter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_raw;
    logic       slow_tick;
    logic [3:0] dbc_count;
    logic       unit_large, unit_fine;
    logic [1:0] filt_mode;
    logic       pin_filt;

    int    n_chk = 0, n_fail = 0, cyc = 0, tick_period = 1;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // reference model state
    logic  mq[$];
    logic  m_lvl;
    int    m_acc;

    always #2 clk = ~clk;

    deglitch_filter dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .slow_tick(slow_tick),
        .dbc_count(dbc_count), .unit_large(unit_large), .unit_fine(unit_fine),
        .filt_mode(filt_mode), .pin_filt(pin_filt)
    );

    function automatic int unit_ticks(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 512;
            default: return 2048;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq = '{1'b0, 1'b0};
            m_lvl = 1'b0;
            m_acc = 0;
        end else begin
            logic old;
            int   span;
            span = ((dbc_count == 0) ? 1 : int'(dbc_count)) * unit_ticks({unit_large, unit_fine});
            old  = mq.pop_front();
            if (filt_mode == 2'b00) begin
                m_lvl = old; m_acc = 0;
            end else if (old == m_lvl) begin
                m_acc = 0;
            end else if ((filt_mode == 2'b01 && !old) || (filt_mode == 2'b10 && old)) begin
                m_lvl = old; m_acc = 0;
            end else if (slow_tick) begin
                if (m_acc + 1 >= span) begin m_lvl = old; m_acc = 0; end
                else m_acc = m_acc + 1;
            end
            mq.push_back(pin_raw);
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pin_filt=%0b expected %0b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: latency=%0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) check_bit(cur_req, pin_filt, m_lvl);
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        slow_tick <= (tick_period != 0) && ((cyc % ((tick_period == 0) ? 1 : tick_period)) == 0);
    end

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_chk++; n_fail++;
            $display("FAIL run limit: cycles=%0d expected below %0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input string req, input int exp);
        logic start;
        int   n;
        start   = pin_filt;
        pin_raw = ~start;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pin_filt == start && n < 40000);
        check_int(req, n, exp);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [3:0] c, input logic [1:0] u);
        filt_mode = m; dbc_count = c; {unit_large, unit_fine} = u;
    endtask

    initial begin
        rst_n = 1'b0; pin_raw = 1'b1; slow_tick = 1'b0;
        set_cfg(2'b00, 4'd0, 2'b00);
        wait_n(3);
        check_bit("R1", pin_filt, 1'b0);
        pin_raw = 1'b0;
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R2 bypass
        cur_req = "R2";
        for (int i = 0; i < 24; i++) begin
            pin_raw = ((i % 5) == 0) || ((i % 3) == 1);
            @(negedge clk);
        end
        pin_raw = 1'b0; wait_n(5);
        measure("R2", 3);
        measure("R2", 3);

        // R3 reject both, span 6
        cur_req = "R3";
        set_cfg(2'b11, 4'd3, 2'b00); wait_n(4);
        measure("R3", 8);
        measure("R3", 8);

        // R4 short pulses and bounce
        cur_req = "R4";
        pin_raw = 1'b1; wait_n(4); pin_raw = 1'b0; wait_n(12);
        check_bit("R4", pin_filt, 1'b0);
        for (int k = 0; k < 6; k++) begin
            pin_raw = 1'b1; wait_n(5);
            pin_raw = 1'b0; wait_n(1);
        end
        wait_n(8);
        check_bit("R4", pin_filt, 1'b0);

        // R5 unit selection with count 1
        cur_req = "R5";
        for (int u = 0; u < 4; u++) begin
            set_cfg(2'b11, 4'd1, 2'(u)); wait_n(3);
            measure("R5", unit_ticks(2'(u)) + 2);
        end
        set_cfg(2'b11, 4'd15, 2'b11); wait_n(3);
        measure("R5", 15 * 2048 + 2);

        // R6 zero count
        cur_req = "R6";
        set_cfg(2'b11, 4'd0, 2'b01); wait_n(3);
        measure("R6", 8 + 2);
        set_cfg(2'b11, 4'd0, 2'b00); wait_n(3);
        measure("R6", 2 + 2);

        // R9 sparse and stopped ticks
        cur_req = "R9";
        tick_period = 4;
        set_cfg(2'b11, 4'd2, 2'b00);
        pin_raw = ~pin_filt; wait_n(40);
        check_bit("R9", pin_filt, pin_raw);
        tick_period = 0; wait_n(2);
        pin_raw = ~pin_filt; wait_n(100);
        check_bit("R9", pin_filt, ~pin_raw);
        tick_period = 1; wait_n(20);
        check_bit("R9", pin_filt, pin_raw);

        // R7 keep low pulses, span 4
        cur_req = "R7";
        set_cfg(2'b11, 4'd2, 2'b00);
        pin_raw = 1'b1; wait_n(12);
        set_cfg(2'b01, 4'd2, 2'b00);
        pin_raw = 1'b0; wait_n(1); pin_raw = 1'b1; wait_n(2);
        check_bit("R7", pin_filt, 1'b0);
        wait_n(12);
        check_bit("R7", pin_filt, 1'b1);
        measure("R7", 3);
        measure("R7", 6);

        // R8 keep high pulses
        cur_req = "R8";
        set_cfg(2'b10, 4'd2, 2'b00); wait_n(2);
        measure("R8", 6);
        pin_raw = 1'b1; wait_n(1); pin_raw = 1'b0; wait_n(2);
        check_bit("R8", pin_filt, 1'b1);
        wait_n(12);
        check_bit("R8", pin_filt, 1'b0);
        measure("R8", 3);

        wait_n(4);
        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule